// File: doc/BRIEF.md
# Bus Master Security Filter

This block sits on the path from one bus master to a downstream memory port and decides, for each request, what security attribute it travels with, or whether it travels at all. The request address is sent out on a combinational attribution port. The port answers in the same cycle with two flags: whether the address is exempt from checking, and whether it is non-secure. These flags are combined with the master's configured security state, sampled when the request is accepted. The request is then forwarded tagged secure, forwarded tagged non-secure, or blocked. A blocked request is answered locally, either as a harmless access (reads give zero, writes are dropped) or with an error that also raises a sticky interrupt.

Both the upstream and downstream sides use separate valid/ready request and response channels. A transfer happens on a clock edge where valid and ready are both high. A source holds valid and its payload stable until ready. Upstream, `m_req_ready` is high only when nothing is outstanding, so at most one transaction is in flight. The master may hold `m_rsp_ready` low for any number of cycles, and the response stays presented until it is taken. Downstream, the block keeps the request presented until `s_req_ready` and takes the response whenever it arrives.

Transfer size is coded as log2 of the byte count (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8). Data is little-endian and lane-aligned from byte 0.

Top module: `sec_filter_top`

## Requirements
- R1: An accepted request whose attribution reports exempt (`attr_exempt`=1) is issued downstream. `s_req_secure` is the inverse of `cfg_master_ns` as sampled at acceptance.
- R2: A non-exempt request attributed non-secure (`attr_nonsec`=1) is issued downstream with `s_req_secure`=0, whatever `cfg_master_ns` is.
- R3: A non-exempt request attributed secure, accepted while `cfg_master_ns`=0, is issued downstream with `s_req_secure`=1.
- R4: A non-exempt request attributed secure, accepted while `cfg_master_ns`=1, is never issued downstream. `s_req_valid` stays low for it.
- R5: A blocked request accepted while `cfg_err_mode`=0 completes with `m_rsp_err`=0 and all-zero `m_rsp_rdata`. A blocked write changes nothing downstream, and `irq` is not raised.
- R6: A blocked request accepted while `cfg_err_mode`=1 completes with `m_rsp_err`=1. If `irq_clr` is low in the acceptance cycle, `irq` is high from the next cycle on.
- R7: `irq_clr` high forces `irq` low in the following cycle. While it is held high, blocked error-mode requests leave `irq` low.
- R8: `irq` is sticky: once high, it stays high until `irq_clr` is asserted, across any later traffic.
- R9: During and right after reset, `irq`, `s_req_valid` and `m_rsp_valid` are low and `m_req_ready` is high.
- R10: For a forwarded request, `s_rsp_err` is returned unchanged as `m_rsp_err`. Write responses carry zero data.
- R11: For a forwarded read of size code s, `m_rsp_rdata` bytes 0 to 2^s-1 equal the downstream data and all higher bytes are zero.
- R12: Only one transaction is outstanding. `m_req_ready` is low from acceptance until the response handshake. Request and response payloads hold stable while their valid waits for ready.
- R13: The tag, address, size and data of an issued request are fixed at acceptance. Changing the configuration inputs afterwards does not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master_ns | input | 1 | Master configured non-secure when high |
| cfg_err_mode | input | 1 | Blocked requests answer with error (high) or read-as-zero (low) |
| irq_clr | input | 1 | Level clear and suppress for the interrupt status |
| irq | output | 1 | Sticky blocked-access interrupt level |
| attr_addr | output | AW | Address presented to the attribution lookup |
| attr_exempt | input | 1 | Lookup result: address exempt from checking |
| attr_nonsec | input | 1 | Lookup result: address is non-secure |
| m_req_valid | input | 1 | Upstream request valid |
| m_req_ready | output | 1 | Upstream request ready |
| m_req_write | input | 1 | Request is a write |
| m_req_addr | input | AW | Request address |
| m_req_size | input | SZW | Size code, log2 of bytes |
| m_req_wdata | input | DW | Write data |
| m_rsp_valid | output | 1 | Upstream response valid |
| m_rsp_ready | input | 1 | Upstream response ready |
| m_rsp_err | output | 1 | Response is an error |
| m_rsp_rdata | output | DW | Read data |
| s_req_valid | output | 1 | Downstream request valid |
| s_req_ready | input | 1 | Downstream request ready |
| s_req_write | output | 1 | Downstream request is a write |
| s_req_addr | output | AW | Downstream address |
| s_req_size | output | SZW | Downstream size code |
| s_req_wdata | output | DW | Downstream write data |
| s_req_secure | output | 1 | Security tag, high for secure |
| s_rsp_valid | input | 1 | Downstream response valid |
| s_rsp_ready | output | 1 | Downstream response ready |
| s_rsp_err | input | 1 | Downstream error status |
| s_rsp_rdata | input | DW | Downstream read data |

## Verification
The bench drives exempt addresses under both master states. A filter that ignored the master state here would tag every exempt access the same way. Secure-attributed accesses from a non-secure master, in both response modes, catch a design that leaks the access downstream, returns stale data, or raises the interrupt in silent mode. The interrupt is tested while cleared, while held clear across an error-mode block (a design that sets status regardless would raise it), and across later allowed traffic (a non-sticky design would drop it). Configuration inputs are flipped while a request waits for downstream ready, and narrow reads check upper-byte zeroing; a design sampling late or passing raw data would show a wrong tag or stray bytes.

// File: rtl/sec_filter_pkg.sv
package sec_filter_pkg;

  typedef enum logic [1:0] {
    ACT_BLOCK_ERR  = 2'd0,
    ACT_BLOCK_ZERO = 2'd1,
    ACT_PASS_SEC   = 2'd2,
    ACT_PASS_NSEC  = 2'd3
  } filt_act_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } ctl_state_e;

  function automatic logic act_is_pass(filt_act_e a);
    return (a == ACT_PASS_SEC) || (a == ACT_PASS_NSEC);
  endfunction

endpackage

// File: rtl/sec_filter_decide.sv
module sec_filter_decide
  import sec_filter_pkg::*;
(
  input  logic      exempt,
  input  logic      nonsec,
  input  logic      master_ns,
  input  logic      err_mode,
  output filt_act_e act
);

  // Priority: exempt first, then non-secure attribution, then master state.
  always_comb begin
    if (exempt) begin
      act = master_ns ? ACT_PASS_NSEC : ACT_PASS_SEC;
    end else if (nonsec) begin
      act = ACT_PASS_NSEC;
    end else if (!master_ns) begin
      act = ACT_PASS_SEC;
    end else begin
      act = err_mode ? ACT_BLOCK_ERR : ACT_BLOCK_ZERO;
    end
  end

endmodule

// File: rtl/sec_filter_lanes.sv
module sec_filter_lanes #(
  parameter int DW  = 64,
  parameter int SZW = 2
) (
  input  logic [SZW-1:0] size,
  output logic [DW-1:0]  mask
);

  localparam int NB = DW / 8;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign mask[i*8 +: 8] = {8{32'(i) < (32'd1 << size)}};
  end

endmodule

// File: rtl/sec_filter_irq.sv
module sec_filter_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic block_err_evt,
  input  logic clr,
  output logic status
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 1'b0;
    end else if (clr) begin
      status <= 1'b0;
    end else if (block_err_evt) begin
      status <= 1'b1;
    end
  end

endmodule

// File: rtl/sec_filter_ctrl.sv
module sec_filter_ctrl
  import sec_filter_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 64,
  parameter int SZW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  filt_act_e      act,
  input  logic           m_req_valid,
  output logic           m_req_ready,
  input  logic           m_req_write,
  input  logic [AW-1:0]  m_req_addr,
  input  logic [SZW-1:0] m_req_size,
  input  logic [DW-1:0]  m_req_wdata,
  output logic           m_rsp_valid,
  input  logic           m_rsp_ready,
  output logic           m_rsp_err,
  output logic [DW-1:0]  m_rsp_rdata,
  output logic           s_req_valid,
  input  logic           s_req_ready,
  output logic           s_req_write,
  output logic [AW-1:0]  s_req_addr,
  output logic [SZW-1:0] s_req_size,
  output logic [DW-1:0]  s_req_wdata,
  output logic           s_req_secure,
  input  logic           s_rsp_valid,
  output logic           s_rsp_ready,
  input  logic           s_rsp_err,
  input  logic [DW-1:0]  s_rsp_rdata,
  output logic           block_err_evt
);

  ctl_state_e     st;
  logic           q_write;
  logic [AW-1:0]  q_addr;
  logic [SZW-1:0] q_size;
  logic [DW-1:0]  q_wdata;
  logic           q_sec;
  logic           r_err;
  logic [DW-1:0]  r_data;
  logic [DW-1:0]  lane_mask;
  logic           accept;

  sec_filter_lanes #(.DW(DW), .SZW(SZW)) u_lanes (
    .size (q_size),
    .mask (lane_mask)
  );

  assign m_req_ready   = (st == ST_IDLE);
  assign accept        = m_req_valid && m_req_ready;
  assign block_err_evt = accept && (act == ACT_BLOCK_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      q_write <= 1'b0;
      q_addr  <= '0;
      q_size  <= '0;
      q_wdata <= '0;
      q_sec   <= 1'b0;
      r_err   <= 1'b0;
      r_data  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            if (act_is_pass(act)) begin
              q_write <= m_req_write;
              q_addr  <= m_req_addr;
              q_size  <= m_req_size;
              q_wdata <= m_req_wdata;
              q_sec   <= (act == ACT_PASS_SEC);
              st      <= ST_ISSUE;
            end else begin
              r_err  <= (act == ACT_BLOCK_ERR);
              r_data <= '0;
              st     <= ST_RESP;
            end
          end
        end
        ST_ISSUE: begin
          if (s_req_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (s_rsp_valid) begin
            r_err  <= s_rsp_err;
            r_data <= q_write ? '0 : (s_rsp_rdata & lane_mask);
            st     <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (m_rsp_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign s_req_valid  = (st == ST_ISSUE);
  assign s_req_write  = q_write;
  assign s_req_addr   = q_addr;
  assign s_req_size   = q_size;
  assign s_req_wdata  = q_wdata;
  assign s_req_secure = q_sec;
  assign s_rsp_ready  = (st == ST_WAIT);
  assign m_rsp_valid  = (st == ST_RESP);
  assign m_rsp_err    = r_err;
  assign m_rsp_rdata  = r_data;

endmodule

// File: rtl/sec_filter_top.sv
module sec_filter_top
  import sec_filter_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64,
  localparam int SZW = $clog2($clog2(DW / 8) + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_master_ns,
  input  logic           cfg_err_mode,
  input  logic           irq_clr,
  output logic           irq,
  output logic [AW-1:0]  attr_addr,
  input  logic           attr_exempt,
  input  logic           attr_nonsec,
  input  logic           m_req_valid,
  output logic           m_req_ready,
  input  logic           m_req_write,
  input  logic [AW-1:0]  m_req_addr,
  input  logic [SZW-1:0] m_req_size,
  input  logic [DW-1:0]  m_req_wdata,
  output logic           m_rsp_valid,
  input  logic           m_rsp_ready,
  output logic           m_rsp_err,
  output logic [DW-1:0]  m_rsp_rdata,
  output logic           s_req_valid,
  input  logic           s_req_ready,
  output logic           s_req_write,
  output logic [AW-1:0]  s_req_addr,
  output logic [SZW-1:0] s_req_size,
  output logic [DW-1:0]  s_req_wdata,
  output logic           s_req_secure,
  input  logic           s_rsp_valid,
  output logic           s_rsp_ready,
  input  logic           s_rsp_err,
  input  logic [DW-1:0]  s_rsp_rdata
);

  filt_act_e act;
  logic      block_err_evt;

  assign attr_addr = m_req_addr;

  sec_filter_decide u_decide (
    .exempt    (attr_exempt),
    .nonsec    (attr_nonsec),
    .master_ns (cfg_master_ns),
    .err_mode  (cfg_err_mode),
    .act       (act)
  );

  sec_filter_ctrl #(.AW(AW), .DW(DW), .SZW(SZW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .act           (act),
    .m_req_valid   (m_req_valid),
    .m_req_ready   (m_req_ready),
    .m_req_write   (m_req_write),
    .m_req_addr    (m_req_addr),
    .m_req_size    (m_req_size),
    .m_req_wdata   (m_req_wdata),
    .m_rsp_valid   (m_rsp_valid),
    .m_rsp_ready   (m_rsp_ready),
    .m_rsp_err     (m_rsp_err),
    .m_rsp_rdata   (m_rsp_rdata),
    .s_req_valid   (s_req_valid),
    .s_req_ready   (s_req_ready),
    .s_req_write   (s_req_write),
    .s_req_addr    (s_req_addr),
    .s_req_size    (s_req_size),
    .s_req_wdata   (s_req_wdata),
    .s_req_secure  (s_req_secure),
    .s_rsp_valid   (s_rsp_valid),
    .s_rsp_ready   (s_rsp_ready),
    .s_rsp_err     (s_rsp_err),
    .s_rsp_rdata   (s_rsp_rdata),
    .block_err_evt (block_err_evt)
  );

  sec_filter_irq u_irq (
    .clk           (clk),
    .rst_n         (rst_n),
    .block_err_evt (block_err_evt),
    .clr           (irq_clr),
    .status        (irq)
  );

endmodule

// File: rtl/sec_filter_chk.sv
module sec_filter_chk #(
  parameter int AW = 32,
  parameter int DW = 64,
  localparam int SZW = $clog2($clog2(DW / 8) + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_master_ns,
  input logic           cfg_err_mode,
  input logic           irq_clr,
  input logic           irq,
  input logic           attr_exempt,
  input logic           attr_nonsec,
  input logic           m_req_valid,
  input logic           m_req_ready,
  input logic           m_rsp_valid,
  input logic           m_rsp_ready,
  input logic           m_rsp_err,
  input logic [DW-1:0]  m_rsp_rdata,
  input logic           s_req_valid,
  input logic           s_req_ready,
  input logic [AW-1:0]  s_req_addr,
  input logic [SZW-1:0] s_req_size,
  input logic           s_req_secure
);

  logic acc;
  assign acc = m_req_valid && m_req_ready;

  assert_exempt_tag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && attr_exempt) |=> (s_req_valid && (s_req_secure == !$past(cfg_master_ns))));

  assert_nonsec_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !attr_exempt && attr_nonsec) |=> (s_req_valid && !s_req_secure));

  assert_secure_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !attr_exempt && !attr_nonsec && !cfg_master_ns) |=> (s_req_valid && s_req_secure));

  assert_block_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !attr_exempt && !attr_nonsec && cfg_master_ns) |=> (!s_req_valid && m_rsp_valid));

  assert_silent_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !attr_exempt && !attr_nonsec && cfg_master_ns && !cfg_err_mode)
      |=> (!m_rsp_err && (m_rsp_rdata == '0)));

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(acc && cfg_err_mode && cfg_master_ns && !irq_clr));

  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq);

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  assert_single_flight_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (s_req_valid || m_rsp_valid) |-> !m_req_ready);

  assert_dn_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (s_req_valid && !s_req_ready)
      |=> (s_req_valid && $stable(s_req_addr) && $stable(s_req_size) && $stable(s_req_secure)));

  assert_up_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rsp_valid && !m_rsp_ready) |=> (m_rsp_valid && $stable(m_rsp_err) && $stable(m_rsp_rdata)));

endmodule

bind sec_filter_top sec_filter_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_sec_filter_top.sv
module tb_sec_filter_top;

  localparam int AW = 32;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_master_ns = 1'b0, cfg_err_mode = 1'b0, irq_clr = 1'b0;
  logic          irq;
  logic [AW-1:0] attr_addr;
  logic          attr_exempt, attr_nonsec;
  logic          m_req_valid = 1'b0, m_req_ready, m_req_write = 1'b0;
  logic [AW-1:0] m_req_addr = '0;
  logic [1:0]    m_req_size = '0;
  logic [DW-1:0] m_req_wdata = '0;
  logic          m_rsp_valid, m_rsp_ready = 1'b0, m_rsp_err;
  logic [DW-1:0] m_rsp_rdata;
  logic          s_req_valid, s_req_ready = 1'b0, s_req_write;
  logic [AW-1:0] s_req_addr;
  logic [1:0]    s_req_size;
  logic [DW-1:0] s_req_wdata;
  logic          s_req_secure;
  logic          s_rsp_valid = 1'b0, s_rsp_ready, s_rsp_err = 1'b0;
  logic [DW-1:0] s_rsp_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] a;
    logic [1:0]    sz;
    logic [DW-1:0] wd;
    logic          sec;
  } dn_t;
  typedef struct packed {
    logic          err;
    logic [DW-1:0] d;
  } up_t;

  dn_t dq[$];
  up_t uq[$];

  always #5 clk = ~clk;

  // Address map model: bit 31 exempt, bit 30 non-secure, bit 12 downstream error.
  assign attr_exempt = attr_addr[31];
  assign attr_nonsec = attr_addr[30];

  sec_filter_top #(.AW(AW), .DW(DW)) dut (.*);

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a);
    return {a ^ 32'h5A5AC3C3, a ^ 32'h12345678};
  endfunction

  function automatic logic [DW-1:0] lmask(logic [1:0] sz);
    logic [DW-1:0] m = '0;
    for (int i = 0; i < 8; i++) if (i < (1 << sz)) m[i*8 +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Downstream responder and scoreboard of issued requests
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && s_req_valid) begin
        dn_t got, exp;
        repeat (2) @(negedge clk);
        got = '{s_req_write, s_req_addr, s_req_size, s_req_wdata, s_req_secure};
        if (dq.size() == 0) begin
          chk("R4 unexpected downstream issue", 64'(got.a), 64'hFFFF_FFFF_FFFF_FFFF);
        end else begin
          exp = dq.pop_front();
          chk("R1 R2 R3 R13 tag", 64'(got.sec), 64'(exp.sec));
          chk("R13 addr", 64'(got.a), 64'(exp.a));
          chk("R13 size", 64'(got.sz), 64'(exp.sz));
          chk("R13 write/data", got.wr ? got.wd : 64'd0, exp.wr ? exp.wd : 64'd0);
        end
        s_req_ready = 1'b1;
        @(negedge clk);
        s_req_ready = 1'b0;
        s_rsp_valid = 1'b1;
        s_rsp_err   = got.a[12];
        s_rsp_rdata = pat(got.a);
        @(negedge clk);
        s_rsp_valid = 1'b0;
      end
    end
  end

  // Upstream response monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && m_rsp_valid && m_rsp_ready) begin
        up_t e;
        if (uq.size() == 0) begin
          chk("R12 spurious response", 64'd1, 64'd0);
        end else begin
          e = uq.pop_front();
          chk("R5 R6 R10 response status", 64'(m_rsp_err), 64'(e.err));
          chk("R5 R10 R11 response data", m_rsp_rdata, e.d);
        end
      end
    end
  end

  task automatic run_txn(input logic wr, input logic [AW-1:0] a, input logic [1:0] sz,
                         input logic ns, input logic em, input int rdly);
    logic pass, sec;
    logic [DW-1:0] wd = ~pat(a);
    if (a[31])       begin pass = 1'b1; sec = !ns; end
    else if (a[30])  begin pass = 1'b1; sec = 1'b0; end
    else if (!ns)    begin pass = 1'b1; sec = 1'b1; end
    else             begin pass = 1'b0; sec = 1'b0; end
    if (pass) begin
      dq.push_back('{wr, a, sz, wd, sec});
      uq.push_back('{a[12], wr ? 64'd0 : (pat(a) & lmask(sz))});
    end else begin
      uq.push_back('{em, 64'd0});
    end
    @(negedge clk);
    cfg_master_ns = ns; cfg_err_mode = em;
    m_req_write = wr; m_req_addr = a; m_req_size = sz; m_req_wdata = wd;
    m_req_valid = 1'b1;
    while (!m_req_ready) @(negedge clk);
    @(negedge clk);
    m_req_valid = 1'b0;
    cfg_master_ns = !ns; cfg_err_mode = !em;   // R13: late config change
    chk("R12 busy after accept", 64'(m_req_ready), 64'd0);
    repeat (rdly) @(negedge clk);
    m_rsp_ready = 1'b1;
    while (!m_rsp_valid) @(negedge clk);
    @(negedge clk);
    m_rsp_ready = 1'b0;
    cfg_master_ns = ns; cfg_err_mode = em;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 irq in reset", 64'(irq), 64'd0);
    chk("R9 s_req_valid in reset", 64'(s_req_valid), 64'd0);
    chk("R9 m_rsp_valid in reset", 64'(m_rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 ready after reset", 64'(m_req_ready), 64'd1);
    chk("R9 irq after reset", 64'(irq), 64'd0);

    run_txn(1'b0, 32'h8000_0010, 2'd3, 1'b0, 1'b0, 0);  // R1 secure master
    run_txn(1'b0, 32'h8000_0020, 2'd0, 1'b1, 1'b0, 1);  // R1 ns master, R11 1 byte
    run_txn(1'b1, 32'h4000_0030, 2'd2, 1'b0, 1'b0, 0);  // R2
    run_txn(1'b0, 32'h4000_0038, 2'd1, 1'b1, 1'b1, 0);  // R2, R11 2 bytes
    run_txn(1'b0, 32'h0000_0040, 2'd1, 1'b0, 1'b1, 0);  // R3
    run_txn(1'b0, 32'h0000_0050, 2'd3, 1'b1, 1'b0, 0);  // R4 R5 read
    run_txn(1'b1, 32'h0000_0058, 2'd3, 1'b1, 1'b0, 0);  // R4 R5 write
    @(negedge clk);
    chk("R5 no irq in silent mode", 64'(irq), 64'd0);
    run_txn(1'b0, 32'h4000_1000, 2'd2, 1'b0, 1'b0, 0);  // R10 downstream error
    run_txn(1'b0, 32'h0000_0060, 2'd2, 1'b1, 1'b1, 2);  // R6
    @(negedge clk);
    chk("R6 irq raised", 64'(irq), 64'd1);
    run_txn(1'b0, 32'h4000_0070, 2'd3, 1'b0, 1'b0, 0);
    @(negedge clk);
    chk("R8 irq sticky", 64'(irq), 64'd1);
    irq_clr = 1'b1;
    @(negedge clk);
    chk("R7 irq cleared", 64'(irq), 64'd0);
    run_txn(1'b0, 32'h0000_0080, 2'd3, 1'b1, 1'b1, 0);  // R7 suppressed
    @(negedge clk);
    chk("R7 irq suppressed while clear held", 64'(irq), 64'd0);
    irq_clr = 1'b0;
    @(negedge clk);
    chk("R7 irq stays low after release", 64'(irq), 64'd0);
    run_txn(1'b1, 32'h0000_0090, 2'd0, 1'b1, 1'b1, 3);  // R6 write, R12 back-pressure
    @(negedge clk);
    chk("R6 irq raised again", 64'(irq), 64'd1);
    repeat (4) @(negedge clk);
    chk("R12 scoreboard drained", 64'(dq.size() + uq.size()), 64'd0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule